// File: doc/BRIEF.md
# I2C Target Receive DMA Engine

This block is the receive side of an I2C controller working as a bus target. It moves each byte that a remote controller writes straight into system memory. A small register file holds the settings: the own 7-bit device address, the memory base address of the receive buffer, the buffer length (programmed as length minus one), a command word with the receive-DMA enable, an interrupt enable word and a sticky interrupt status word. A separate status register holds the number of bytes received.

A byte-level front end presents three kinds of events. One is the start of an address-matched write transfer. Another is a received data byte. The third is a stop condition. The engine answers each start or byte with a one-cycle acknowledge or not-acknowledge pulse. It writes accepted bytes through a one-byte-per-beat memory write port. On stop it raises a single interrupt line, which stays high while any status bit is set.

Top module: `i2c_tgt_rxdma`

## Requirements
- R1: After reset every register reads zero and `irq`, `bus_ack`, `bus_nack` and `mem_we` are low.
- R2: A start while command bit 0 (receive DMA enable) is clear gives a `bus_nack` pulse one cycle later. Later bytes of that transfer are refused with no memory write, and its stop sets no status bit.
- R3: A start while command bit 0 is set gives a `bus_ack` pulse one cycle later. It clears the received-byte count (register 6). It aims the write pointer at the base address (register 1). It allows length-field + 1 bytes.
- R4: Each byte inside an accepted transfer that still has room gives, one cycle later, a `mem_we` beat at the current pointer with that byte, and a `bus_ack`. The pointer advances by one and the count at register 6 rises by one.
- R5: A byte that arrives when the buffer is full gets `bus_nack` with no memory write. It also sets overflow status bit 20.
- R6: A stop that ends an accepted transfer sets status bits 0 (receive done), 1 (stop seen), 2 (address match) and 16 (packet done) together, two cycles after the stop input.
- R7: A write to the length register (register 2) with bit 31 set updates only the length field (bits LEN_W-1:0). A write with bit 31 clear replaces all stored bits (the length field and bits 30:16).
- R8: A write to the command register (register 3, 16 stored bits) with bit 15 set ORs the written value in. Otherwise the written value replaces the register.
- R9: When interrupt enable bit 16 is set, a status write clears bits 17:0 and keeps bits 31:18, and only when status bit 16 is pending and written as one. Any other status write in that mode has no effect. With enable bit 16 clear, status (register 5) is write-one-to-clear.
- R10: `irq` is high exactly while the status register is non-zero.
- R11: Any write to register 6 resets the received-byte count to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 own addr, 1 base, 2 length, 3 command, 4 irq enable, 5 status, 6 byte count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| tgt_addr | output | 7 | Programmed own device address for the address matcher |
| bus_start | input | 1 | Start of an address-matched write transfer |
| bus_byte_vld | input | 1 | A received data byte is presented |
| bus_byte | input | 8 | Received data byte |
| bus_stop | input | 1 | Stop condition |
| bus_ack | output | 1 | Acknowledge pulse |
| bus_nack | output | 1 | Not-acknowledge pulse |
| mem_we | output | 1 | Memory write beat |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills a four-byte buffer and then sends a fifth byte. A design that writes past the end would produce an unexpected memory beat, and one that fails to flag the overflow would leave bit 20 clear. It clears packet-done status while overflow is pending. A design that treats that path as plain write-one-to-clear would drop the overflow bit or ignore the masked write. The length and command registers are written in both update modes. A broken take-bit or OR path shows up as wrong upper length bits or lost command bits. A transfer started with DMA disabled must be refused, and a design that accepts it would acknowledge or write memory.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int REG_IDX_W = 3;

   typedef enum logic [REG_IDX_W-1:0] {
      RG_OWN  = 3'd0,
      RG_BASE = 3'd1,
      RG_LEN  = 3'd2,
      RG_CMD  = 3'd3,
      RG_IEN  = 3'd4,
      RG_STAT = 3'd5,
      RG_CNT  = 3'd6,
      RG_NONE = 3'd7
   } reg_sel_e;

   localparam int ST_RXDONE = 0;
   localparam int ST_STOP   = 1;
   localparam int ST_MATCH  = 2;
   localparam int ST_PKT    = 16;
   localparam int ST_OVF    = 20;

   localparam int LEN_TAKE_BIT = 31;
   localparam int CMD_OR_BIT   = 15;
   localparam int CMD_DMA_BIT  = 0;
   localparam int CMD_W        = 16;

   localparam logic [31:0] PKT_CLR_MASK = 32'h0003_FFFF;

   function automatic logic [31:0] stop_bits();
      logic [31:0] v;
      v = '0;
      v[ST_RXDONE] = 1'b1;
      v[ST_STOP]   = 1'b1;
      v[ST_MATCH]  = 1'b1;
      v[ST_PKT]    = 1'b1;
      return v;
   endfunction
endpackage

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [REG_IDX_W-1:0] wr_idx,
   input  logic [31:0]          wr_data,
   input  logic                 evt_stop,
   input  logic                 evt_ovf,
   output logic [6:0]           own_addr,
   output logic [ADDR_W-1:0]    base_addr,
   output logic [31:0]          len_reg,
   output logic [CMD_W-1:0]     cmd_reg,
   output logic [31:0]          ien_reg,
   output logic [31:0]          stat_reg,
   output logic                 cnt_clr,
   output logic                 irq
);
   localparam logic [31:0] LEN_FIELD = (32'd1 << LEN_W) - 32'd1;
   localparam logic [31:0] LEN_MASK  = 32'h7FFF_0000 | LEN_FIELD;

   logic [31:0] stat_nxt;
   logic        hit_stat;

   assign hit_stat = wr_en && (wr_idx == RG_STAT);
   assign cnt_clr  = wr_en && (wr_idx == RG_CNT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_addr  <= '0;
         base_addr <= '0;
         len_reg   <= '0;
         cmd_reg   <= '0;
         ien_reg   <= '0;
      end else if (wr_en) begin
         case (wr_idx)
            RG_OWN:  own_addr  <= wr_data[6:0];
            RG_BASE: base_addr <= wr_data[ADDR_W-1:0];
            RG_LEN: begin
               if (wr_data[LEN_TAKE_BIT])
                  len_reg[LEN_W-1:0] <= wr_data[LEN_W-1:0];
               else
                  len_reg <= wr_data & LEN_MASK;
            end
            RG_CMD: begin
               if (wr_data[CMD_OR_BIT])
                  cmd_reg <= cmd_reg | wr_data[CMD_W-1:0];
               else
                  cmd_reg <= wr_data[CMD_W-1:0];
            end
            RG_IEN:  ien_reg <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      stat_nxt = stat_reg;
      if (hit_stat) begin
         if (ien_reg[ST_PKT]) begin
            if (stat_reg[ST_PKT] && wr_data[ST_PKT])
               stat_nxt = stat_reg & ~PKT_CLR_MASK;
         end else begin
            stat_nxt = stat_reg & ~wr_data;
         end
      end
      if (evt_stop)
         stat_nxt = stat_nxt | stop_bits();
      if (evt_ovf)
         stat_nxt[ST_OVF] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_reg <= '0;
      else        stat_reg <= stat_nxt;
   end

   assign irq = |stat_reg;

   AST_STOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_stop |=> (stat_reg[ST_PKT] && stat_reg[ST_MATCH] && stat_reg[ST_STOP] && stat_reg[ST_RXDONE])); // R6
   AST_PKT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stat && ien_reg[ST_PKT] && stat_reg[ST_PKT] && wr_data[ST_PKT] && !evt_stop && !evt_ovf)
      |=> (stat_reg[17:0] == 18'd0 && stat_reg[31:18] == $past(stat_reg[31:18]))); // R9
   AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_stat && !ien_reg[ST_PKT] && !evt_stop && !evt_ovf)
      |=> ((stat_reg & $past(wr_data)) == 32'd0)); // R9
   AST_IRQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_reg == 32'd0) |-> !irq); // R10
endmodule

// File: rtl/i2c_tgt_rx_engine.sv
module i2c_tgt_rx_engine
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int LEN_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dma_en,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic              cnt_clr,
   input  logic              bus_start,
   input  logic              bus_byte_vld,
   input  logic [7:0]        bus_byte,
   input  logic              bus_stop,
   output logic              bus_ack,
   output logic              bus_nack,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic [LEN_W:0]    rx_cnt,
   output logic              evt_stop,
   output logic              evt_ovf
);
   localparam int REM_W = LEN_W + 1;

   logic              active;
   logic [ADDR_W-1:0] ptr;
   logic [REM_W-1:0]  remain;
   logic              room;

   assign room = (remain != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         ptr       <= '0;
         remain    <= '0;
         rx_cnt    <= '0;
         bus_ack   <= 1'b0;
         bus_nack  <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         evt_stop  <= 1'b0;
         evt_ovf   <= 1'b0;
      end else begin
         bus_ack  <= 1'b0;
         bus_nack <= 1'b0;
         mem_we   <= 1'b0;
         evt_stop <= 1'b0;
         evt_ovf  <= 1'b0;
         if (cnt_clr) rx_cnt <= '0;
         if (bus_start) begin
            if (dma_en) begin
               active  <= 1'b1;
               ptr     <= base_addr;
               remain  <= REM_W'(len_m1) + REM_W'(1);
               rx_cnt  <= '0;
               bus_ack <= 1'b1;
            end else begin
               active   <= 1'b0;
               bus_nack <= 1'b1;
            end
         end else if (bus_byte_vld) begin
            if (active && room) begin
               mem_we    <= 1'b1;
               mem_addr  <= ptr;
               mem_wdata <= bus_byte;
               ptr       <= ptr + ADDR_W'(1);
               remain    <= remain - REM_W'(1);
               rx_cnt    <= rx_cnt + REM_W'(1);
               bus_ack   <= 1'b1;
            end else begin
               bus_nack <= 1'b1;
               if (active) evt_ovf <= 1'b1;
            end
         end else if (bus_stop) begin
            if (active) evt_stop <= 1'b1;
            active <= 1'b0;
         end
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_byte_vld && !bus_start && !room) |=> (!mem_we && bus_nack)); // R5
   AST_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_start && !dma_en) |=> (bus_nack && !bus_ack)); // R2
   AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_ack && bus_nack)); // R4
   AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr && !bus_byte_vld) |=> (rx_cnt == '0)); // R11
   AST_WRITE_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> bus_ack); // R4
endmodule

// File: rtl/i2c_tgt_rxdma.sv
module i2c_tgt_rxdma
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int LEN_W    = 12,
   parameter int READ_LAT = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [REG_IDX_W-1:0] reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   output logic [6:0]           tgt_addr,
   input  logic                 bus_start,
   input  logic                 bus_byte_vld,
   input  logic [7:0]           bus_byte,
   input  logic                 bus_stop,
   output logic                 bus_ack,
   output logic                 bus_nack,
   output logic                 mem_we,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [7:0]           mem_wdata,
   output logic                 irq
);
   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_aw
         $error("ADDR_W must be 1..32");
      end
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_lw
         $error("LEN_W must be 1..16");
      end
      if (READ_LAT != 0 && READ_LAT != 1) begin : g_bad_rl
         $error("READ_LAT must be 0 or 1");
      end
   endgenerate

   logic [ADDR_W-1:0] base_addr;
   logic [31:0]       len_reg;
   logic [CMD_W-1:0]  cmd_reg;
   logic [31:0]       ien_reg;
   logic [31:0]       stat_reg;
   logic              cnt_clr;
   logic [LEN_W:0]    rx_cnt;
   logic              evt_stop;
   logic              evt_ovf;
   logic [31:0]       rd_mux;

   i2c_tgt_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (reg_we),
      .wr_idx    (reg_addr),
      .wr_data   (reg_wdata),
      .evt_stop  (evt_stop),
      .evt_ovf   (evt_ovf),
      .own_addr  (tgt_addr),
      .base_addr (base_addr),
      .len_reg   (len_reg),
      .cmd_reg   (cmd_reg),
      .ien_reg   (ien_reg),
      .stat_reg  (stat_reg),
      .cnt_clr   (cnt_clr),
      .irq       (irq)
   );

   i2c_tgt_rx_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_eng (
      .clk          (clk),
      .rst_n        (rst_n),
      .dma_en       (cmd_reg[CMD_DMA_BIT]),
      .base_addr    (base_addr),
      .len_m1       (len_reg[LEN_W-1:0]),
      .cnt_clr      (cnt_clr),
      .bus_start    (bus_start),
      .bus_byte_vld (bus_byte_vld),
      .bus_byte     (bus_byte),
      .bus_stop     (bus_stop),
      .bus_ack      (bus_ack),
      .bus_nack     (bus_nack),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .rx_cnt       (rx_cnt),
      .evt_stop     (evt_stop),
      .evt_ovf      (evt_ovf)
   );

   always_comb begin
      case (reg_addr)
         RG_OWN:  rd_mux = 32'(tgt_addr);
         RG_BASE: rd_mux = 32'(base_addr);
         RG_LEN:  rd_mux = len_reg;
         RG_CMD:  rd_mux = 32'(cmd_reg);
         RG_IEN:  rd_mux = ien_reg;
         RG_STAT: rd_mux = stat_reg;
         RG_CNT:  rd_mux = 32'(rx_cnt);
         default: rd_mux = '0;
      endcase
   end

   generate
      if (READ_LAT == 0) begin : g_rd_comb
         assign reg_rdata = rd_mux;
      end else begin : g_rd_reg
         logic [31:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign reg_rdata = rd_q;
      end
   endgenerate

   AST_IRQ_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      evt_stop |=> irq); // R6
   AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      evt_ovf |=> stat_reg[ST_OVF]); // R5
endmodule

// File: tb/sim_i2c_tgt_rxdma.sv
`timescale 1ns/100ps
module sim_i2c_tgt_rxdma;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic [6:0]    tgt_addr;
   logic          bus_start = 1'b0;
   logic          bus_byte_vld = 1'b0;
   logic [7:0]    bus_byte = '0;
   logic          bus_stop = 1'b0;
   logic          bus_ack, bus_nack, mem_we, irq;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_wdata;

   int n_chk = 0;
   int n_fail = 0;
   logic [AW+7:0] exp_q[$];

   always #2 clk = ~clk;

   i2c_tgt_rxdma u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tgt_addr(tgt_addr),
      .bus_start(bus_start), .bus_byte_vld(bus_byte_vld), .bus_byte(bus_byte),
      .bus_stop(bus_stop), .bus_ack(bus_ack), .bus_nack(bus_nack),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: pops expected memory beats
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'hFFFF_FFFF);
         end else begin
            logic [AW+7:0] e;
            e = exp_q.pop_front();
            check("R4 mem beat", 32'({mem_addr, mem_wdata}), 32'(e));
         end
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic start(input string req, input logic exp_ack);
      @(posedge clk); #1; bus_start = 1'b1;
      @(posedge clk); #1; bus_start = 1'b0;
      check(req, {30'd0, bus_ack, bus_nack}, exp_ack ? 32'd2 : 32'd1);
   endtask

   task automatic send(input string req, input logic [7:0] d, input logic exp_ack,
                       input logic [AW-1:0] ea);
      if (exp_ack) exp_q.push_back({ea, d});
      @(posedge clk); #1; bus_byte_vld = 1'b1; bus_byte = d;
      @(posedge clk); #1; bus_byte_vld = 1'b0;
      check(req, {30'd0, bus_ack, bus_nack}, exp_ack ? 32'd2 : 32'd1);
   endtask

   task automatic stop();
      @(posedge clk); #1; bus_stop = 1'b1;
      @(posedge clk); #1; bus_stop = 1'b0;
      @(posedge clk); #1;
   endtask

   initial begin
      #(4 * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 outputs", {28'd0, irq, bus_ack, bus_nack, mem_we}, 32'd0);
      rd("R1 status", 3'd5, 32'd0);
      rd("R1 command", 3'd3, 32'd0);
      rd("R1 length", 3'd2, 32'd0);

      // length register update modes
      wr(3'd2, 32'h00AB_0005);
      rd("R7 full write", 3'd2, 32'h00AB_0005);
      wr(3'd2, 32'h80CD_0007);
      rd("R7 take write", 3'd2, 32'h00AB_0007);
      wr(3'd2, 32'h0000_0002);
      rd("R7 replace", 3'd2, 32'h0000_0002);

      // command register update modes
      wr(3'd3, 32'h0000_0002);
      wr(3'd3, 32'h0000_8001);
      rd("R8 or-in", 3'd3, 32'h0000_8003);
      wr(3'd3, 32'h0000_0004);
      rd("R8 replace", 3'd3, 32'h0000_0004);

      // refused transfer
      start("R2 start refused", 1'b0);
      send("R2 byte refused", 8'h55, 1'b0, '0);
      stop();
      rd("R2 no status", 3'd5, 32'd0);
      check("R2 irq low", {31'd0, irq}, 32'd0);

      // accepted transfer with overflow
      wr(3'd1, 32'h0000_0100);
      wr(3'd2, 32'h8000_0003);
      wr(3'd3, 32'h0000_0001);
      start("R3 start ack", 1'b1);
      for (int i = 0; i < 4; i++)
         send("R4 byte ack", 8'hA0 + 8'(i), 1'b1, AW'(16'h100 + i));
      send("R5 full nack", 8'hA4, 1'b0, '0);
      rd("R4 count", 3'd6, 32'd4);
      rd("R5 overflow", 3'd5, 32'h0010_0000);
      stop();
      rd("R6 stop bits", 3'd5, 32'h0011_0007);
      check("R10 irq high", {31'd0, irq}, 32'd1);

      // packet-done clear path
      wr(3'd4, 32'h0001_0000);
      wr(3'd5, 32'h0000_FFFF);
      rd("R9 ignored write", 3'd5, 32'h0011_0007);
      wr(3'd5, 32'h0001_0000);
      rd("R9 masked clear", 3'd5, 32'h0010_0000);
      check("R10 irq kept", {31'd0, irq}, 32'd1);
      wr(3'd4, 32'h0);
      wr(3'd5, 32'h0010_0000);
      rd("R9 w1c", 3'd5, 32'd0);
      check("R10 irq low", {31'd0, irq}, 32'd0);

      // second transfer: count reset at start, plain w1c
      wr(3'd1, 32'h0000_0200);
      wr(3'd2, 32'h0000_0001);
      start("R3 start ack 2", 1'b1);
      rd("R3 count cleared", 3'd6, 32'd0);
      send("R4 byte 2a", 8'h11, 1'b1, AW'(16'h200));
      send("R4 byte 2b", 8'h22, 1'b1, AW'(16'h201));
      stop();
      rd("R6 stop bits 2", 3'd5, 32'h0001_0007);
      wr(3'd5, 32'h0000_0001);
      rd("R9 partial w1c", 3'd5, 32'h0001_0006);
      wr(3'd5, 32'h0001_0006);
      check("R10 irq low 2", {31'd0, irq}, 32'd0);
      rd("R11 before clear", 3'd6, 32'd2);
      wr(3'd6, 32'h0000_1234);
      rd("R11 count reset", 3'd6, 32'd0);

      repeat (3) @(posedge clk);
      check("R4 queue drained", 32'(exp_q.size()), 32'd0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule